// File: doc/BRIEF.md
# Parallel Programming Port Target Handshake

This block sits on the target side of a parallel programming port. An external programmer drives a command strobe, a 4-bit operation code and a 16-bit data word; the block captures the code and the word when the strobe goes low and pulls its ready line low to acknowledge. The ready line stays low for as long as the command is in progress and goes high again only when the command is finished and the programmer has released the strobe.

Operation codes with the read-select bit clear are write-type. The block hands the captured code and word to a command executor through a one-cycle start pulse and waits for that executor's done pulse. Operation codes with the read-select bit set are read-type. The block waits for the programmer's output-enable, reads the word whose address is the low bits of the captured data from a synchronous memory port (one cycle of read latency), turns on its data drivers with that word and then pulls its data-valid line low. When output-enable returns high it turns the drivers off and releases data-valid.

The strobe and the output-enable come from off-chip and pass through two-flop synchronizers. The bidirectional data pins are split into an input, an output and an output-enable, so the pad ring owns the actual tristate buffer.

Top module: `pprog_responder`

## Requirements
- R1: While reset is high and after it is released, the ready output is high, the data-valid output (active low) is high, the data output-enable is low and no start or memory read is issued.
- R2: The operation code and data word presented on the input pins in the clock edge that registers the strobe as low are captured together and appear on the executor outputs; later changes on the data input do not alter them.
- R3: Ready falls on the third rising clock edge after the strobe input goes low (two synchronizer stages plus one control register).
- R4: For a write-type command exactly one single-cycle start pulse is issued, and ready rises only after the executor's done pulse has been received and the strobe has been seen high, in either order.
- R5: Bit 3 of the operation code selects the class: 1 is read-type, 0 is write-type; a read-type command never issues a start pulse and a write-type command never enables the data drivers nor lowers data-valid.
- R6: For a read-type command the data drivers stay off until output-enable (active low) is seen low; afterwards the data output carries the memory word and is stable while data-valid is low.
- R7: Data-valid goes low only while the drivers are on; after output-enable returns high the drivers turn off and data-valid goes high in the same cycle, and ready stays low until the strobe is seen high.
- R8: The memory address of a read is the low ADDR_W bits of the captured data word.
- R9: The data drivers are on only inside the data phase of a read, never while ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_n_i | input | 1 | Command strobe from programmer, active low, asynchronous |
| oe_n_i | input | 1 | Output-enable from programmer, active low, asynchronous |
| mode_i | input | MODE_W | Operation code pins |
| data_i | input | DATA_W | Data pins, input side |
| data_o | output | DATA_W | Data pins, output side |
| data_oe_o | output | 1 | Enable for the data pin drivers |
| rdy_o | output | 1 | Ready towards the programmer, low while busy |
| valid_n_o | output | 1 | Read data valid, active low |
| exec_start_o | output | 1 | One-cycle start pulse to the command executor |
| exec_mode_o | output | MODE_W | Captured operation code |
| exec_data_o | output | DATA_W | Captured data word |
| exec_done_i | input | 1 | Done pulse from the command executor |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after the request |

## Verification
The bench builds the block with a 16-bit data word, a 4-bit operation code and ADDR_W set to 4. With these values every one of the sixteen operation codes is run through the handshake, and every memory address is read back against a word computed arithmetically from its address. Executor done delays from zero to a dozen cycles are combined with strobe releases both before and after done, which brings both orders of the ready gating within reach.

// File: rtl/pprog_pkg.sv
package pprog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_EXEC,
    ST_RD_WAIT_OE,
    ST_RD_ISSUE,
    ST_RD_LOAD,
    ST_RD_VALID,
    ST_RD_HOLD,
    ST_RD_CLOSE
  } pp_state_t;

endpackage

// File: rtl/pprog_sync.sv
module pprog_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          chain_q[s] <= RST_VAL;
        end else if (s == 0) begin
          chain_q[s] <= async_i;
        end else begin
          chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pprog_datapath.sv
module pprog_datapath #(
  parameter int DATA_W = 16,
  parameter int MODE_W = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_en,
  input  logic              load_en,
  input  logic              drive_clr,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [MODE_W-1:0] mode_q,
  output logic [DATA_W-1:0] data_q,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] rd_data_q,
  output logic              drive_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      data_q <= '0;
    end else if (latch_en) begin
      mode_q <= mode_i;
      data_q <= data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q <= '0;
      drive_q   <= 1'b0;
    end else if (load_en) begin
      rd_data_q <= mem_rdata_i;
      drive_q   <= 1'b1;
    end else if (drive_clr) begin
      drive_q   <= 1'b0;
    end
  end

  assign addr_o = data_q[ADDR_W-1:0];

endmodule

// File: rtl/pprog_ctrl.sv
module pprog_ctrl
  import pprog_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_s,
  input  logic oe_s,
  input  logic is_read,
  input  logic exec_done_i,
  output logic latch_en,
  output logic load_en,
  output logic drive_clr,
  output logic exec_start_o,
  output logic mem_rd_o,
  output logic rdy_o,
  output logic valid_n_o
);

  pp_state_t state_q;
  logic      done_seen_q;
  logic      cmd_high_q;
  logic      done_now;
  logic      cmd_now;

  assign latch_en  = (state_q == ST_IDLE) && !cmd_s;
  assign load_en   = (state_q == ST_RD_LOAD);
  assign drive_clr = (state_q == ST_RD_HOLD) && oe_s;
  assign done_now  = done_seen_q || exec_done_i;
  assign cmd_now   = cmd_high_q || cmd_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      rdy_o        <= 1'b1;
      valid_n_o    <= 1'b1;
      exec_start_o <= 1'b0;
      mem_rd_o     <= 1'b0;
      done_seen_q  <= 1'b0;
      cmd_high_q   <= 1'b0;
    end else begin
      exec_start_o <= 1'b0;
      mem_rd_o     <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          done_seen_q <= 1'b0;
          cmd_high_q  <= 1'b0;
          if (!cmd_s) begin
            rdy_o <= 1'b0;
            if (is_read) begin
              state_q <= ST_RD_WAIT_OE;
            end else begin
              exec_start_o <= 1'b1;
              state_q      <= ST_WR_EXEC;
            end
          end
        end
        ST_WR_EXEC: begin
          if (exec_done_i) done_seen_q <= 1'b1;
          if (cmd_s)       cmd_high_q  <= 1'b1;
          if (done_now && cmd_now) begin
            rdy_o   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_RD_WAIT_OE: begin
          if (!oe_s) begin
            mem_rd_o <= 1'b1;
            state_q  <= ST_RD_ISSUE;
          end
        end
        ST_RD_ISSUE: state_q <= ST_RD_LOAD;
        ST_RD_LOAD:  state_q <= ST_RD_VALID;
        ST_RD_VALID: begin
          valid_n_o <= 1'b0;
          state_q   <= ST_RD_HOLD;
        end
        ST_RD_HOLD: begin
          if (oe_s) begin
            valid_n_o <= 1'b1;
            state_q   <= ST_RD_CLOSE;
          end
        end
        ST_RD_CLOSE: begin
          if (cmd_s) begin
            rdy_o   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pprog_responder.sv
module pprog_responder #(
  parameter int DATA_W      = 16,
  parameter int MODE_W      = 4,
  parameter int ADDR_W      = 8,
  parameter int RD_BIT      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_n_i,
  input  logic              oe_n_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rdy_o,
  output logic              valid_n_o,
  output logic              exec_start_o,
  output logic [MODE_W-1:0] exec_mode_o,
  output logic [DATA_W-1:0] exec_data_o,
  input  logic              exec_done_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  localparam int NSYNC = 2;

  logic [NSYNC-1:0] sync_vec;
  logic             cmd_s;
  logic             oe_s;
  logic             latch_en;
  logic             load_en;
  logic             drive_clr;

  pprog_sync #(
    .WIDTH   (NSYNC),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({NSYNC{1'b1}})
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({oe_n_i, cmd_n_i}),
    .sync_o  (sync_vec)
  );

  assign cmd_s = sync_vec[0];
  assign oe_s  = sync_vec[1];

  pprog_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cmd_s        (cmd_s),
    .oe_s         (oe_s),
    .is_read      (mode_i[RD_BIT]),
    .exec_done_i  (exec_done_i),
    .latch_en     (latch_en),
    .load_en      (load_en),
    .drive_clr    (drive_clr),
    .exec_start_o (exec_start_o),
    .mem_rd_o     (mem_rd_o),
    .rdy_o        (rdy_o),
    .valid_n_o    (valid_n_o)
  );

  pprog_datapath #(
    .DATA_W (DATA_W),
    .MODE_W (MODE_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .latch_en    (latch_en),
    .load_en     (load_en),
    .drive_clr   (drive_clr),
    .mode_i      (mode_i),
    .data_i      (data_i),
    .mem_rdata_i (mem_rdata_i),
    .mode_q      (exec_mode_o),
    .data_q      (exec_data_o),
    .addr_o      (mem_addr_o),
    .rd_data_q   (data_o),
    .drive_q     (data_oe_o)
  );

endmodule

// File: rtl/pprog_checker.sv
module pprog_checker #(
  parameter int DATA_W = 16,
  parameter int MODE_W = 4,
  parameter int RD_BIT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_s,
  input logic              rdy_o,
  input logic              valid_n_o,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] data_o,
  input logic              exec_start_o,
  input logic [MODE_W-1:0] exec_mode_o
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (rdy_o && valid_n_o && !data_oe_o && !exec_start_o)); // R1

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    exec_start_o |=> !exec_start_o); // R4

  AST_RDY_AFTER_CMD_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_o) |-> $past(cmd_s)); // R4

  AST_NO_START_ON_READ: assert property (@(posedge clk) disable iff (rst)
    exec_start_o |-> !exec_mode_o[RD_BIT]); // R5

  AST_READ_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!valid_n_o && $past(!valid_n_o)) |-> $stable(data_o)); // R6

  AST_VALID_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !valid_n_o |-> data_oe_o); // R7

  AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> !rdy_o); // R9

endmodule

bind pprog_responder pprog_checker #(
  .DATA_W (DATA_W),
  .MODE_W (MODE_W),
  .RD_BIT (RD_BIT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_s        (cmd_s),
  .rdy_o        (rdy_o),
  .valid_n_o    (valid_n_o),
  .data_oe_o    (data_oe_o),
  .data_o       (data_o),
  .exec_start_o (exec_start_o),
  .exec_mode_o  (exec_mode_o)
);

// File: tb/tb_pprog_responder.sv
`timescale 1ns/1ps
module tb_pprog_responder;

  localparam int DATA_W = 16;
  localparam int MODE_W = 4;
  localparam int ADDR_W = 4;
  localparam int RD_BIT = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_n = 1'b1;
  logic              oe_n = 1'b1;
  logic [MODE_W-1:0] mode = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic              doe;
  logic              rdy;
  logic              valid_n;
  logic              start;
  logic [MODE_W-1:0] x_mode;
  logic [DATA_W-1:0] x_data;
  logic              done = 1'b0;
  logic              mrd;
  logic [ADDR_W-1:0] maddr;
  logic [DATA_W-1:0] mrdata = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int start_cnt = 0;
  int done_cnt = 0;
  int drive_cnt = 0;
  int valid_cnt = 0;
  int exec_delay = 0;
  int exec_cnt = 0;
  bit exec_busy = 1'b0;
  logic [MODE_W-1:0] rec_mode = '0;
  logic [DATA_W-1:0] rec_data = '0;

  always #2.5 clk = ~clk;

  pprog_responder #(
    .DATA_W (DATA_W),
    .MODE_W (MODE_W),
    .ADDR_W (ADDR_W),
    .RD_BIT (RD_BIT)
  ) dut (
    .clk          (clk),
    .rst          (rst),
    .cmd_n_i      (cmd_n),
    .oe_n_i       (oe_n),
    .mode_i       (mode),
    .data_i       (din),
    .data_o       (dout),
    .data_oe_o    (doe),
    .rdy_o        (rdy),
    .valid_n_o    (valid_n),
    .exec_start_o (start),
    .exec_mode_o  (x_mode),
    .exec_data_o  (x_data),
    .exec_done_i  (done),
    .mem_rd_o     (mrd),
    .mem_addr_o   (maddr),
    .mem_rdata_i  (mrdata)
  );

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] w;
    w = DATA_W'(a) * 16'h1357;
    return w ^ 16'hC3A5;
  endfunction

  // memory model, one cycle read latency
  always @(posedge clk) if (mrd) mrdata <= mem_word(maddr);

  // executor model and event counters
  always @(posedge clk) begin
    done <= 1'b0;
    if (start) begin
      start_cnt <= start_cnt + 1;
      rec_mode  <= x_mode;
      rec_data  <= x_data;
      exec_cnt  <= exec_delay;
      exec_busy <= 1'b1;
    end else if (exec_busy) begin
      if (exec_cnt == 0) begin
        done      <= 1'b1;
        done_cnt  <= done_cnt + 1;
        exec_busy <= 1'b0;
      end else begin
        exec_cnt <= exec_cnt - 1;
      end
    end
    if (doe)      drive_cnt <= drive_cnt + 1;
    if (!valid_n) valid_cnt <= valid_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic do_write(input logic [MODE_W-1:0] m, input logic [DATA_W-1:0] d,
                          input int delay, input int hold);
    int n;
    int s0, d0, dr0, v0;
    bit held_ok;
    s0 = start_cnt; d0 = done_cnt; dr0 = drive_cnt; v0 = valid_cnt;
    exec_delay = delay;
    mode = m; din = d; cmd_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (rdy && n < 20);
    chk(n == 3, "R3", "write rdy fall cycle", n, 3);
    din = ~d; mode = ~m;
    held_ok = 1'b1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (rdy) held_ok = 1'b0;
    end
    chk(held_ok, "R4", "rdy low while strobe held", 32'(held_ok), 1);
    cmd_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!rdy && n < 60);
    chk(rdy, "R4", "rdy returns high", 32'(rdy), 1);
    chk(done_cnt == d0 + 1, "R4", "done before rdy rise", done_cnt - d0, 1);
    chk(start_cnt == s0 + 1, "R4", "one start pulse", start_cnt - s0, 1);
    chk(rec_mode == m, "R2", "captured mode", 32'(rec_mode), 32'(m));
    chk(rec_data == d, "R2", "captured data", 32'(rec_data), 32'(d));
    chk(x_data == d, "R2", "held data after pin change", 32'(x_data), 32'(d));
    chk(drive_cnt == dr0 && valid_cnt == v0, "R5", "no drive on write",
        drive_cnt - dr0 + valid_cnt - v0, 0);
  endtask

  task automatic do_read(input logic [MODE_W-1:0] m, input logic [DATA_W-1:0] d);
    int n;
    int s0;
    bit ok;
    logic [DATA_W-1:0] exp;
    exp = mem_word(d[ADDR_W-1:0]);
    s0 = start_cnt;
    mode = m; din = d; cmd_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (rdy && n < 20);
    chk(n == 3, "R3", "read rdy fall cycle", n, 3);
    din = ~d;
    ok = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (doe || !valid_n) ok = 1'b0;
    end
    chk(ok, "R6", "no drive before oe low", 32'(doe), 0);
    oe_n = 1'b0;
    ok = 1'b1;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (!valid_n && !doe) ok = 1'b0;
    end while (valid_n && n < 20);
    chk(ok, "R7", "valid only with drive", 32'(doe), 1);
    chk(!valid_n && doe, "R6", "read phase entered", 32'({doe, valid_n}), 32'h2);
    chk(dout == exp, "R8", "read word from address", 32'(dout), 32'(exp));
    repeat (3) @(negedge clk);
    chk(dout == exp && !valid_n, "R6", "read word held", 32'(dout), 32'(exp));
    oe_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!valid_n && n < 20);
    chk(valid_n && !doe, "R7", "drivers off with valid high", 32'({doe, valid_n}), 32'h1);
    ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (rdy || doe) ok = 1'b0;
    end
    chk(ok, "R7", "rdy low until strobe high", 32'(rdy), 0);
    cmd_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!rdy && n < 20);
    chk(rdy && n == 3, "R7", "rdy rise after strobe", n, 3);
    chk(start_cnt == s0, "R5", "no start on read", start_cnt - s0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=finished");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(rdy && valid_n && !doe && !start && !mrd, "R1", "state in reset",
        32'({rdy, valid_n, doe, start, mrd}), 32'h18);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(rdy && valid_n && !doe && start_cnt == 0, "R1", "state after reset",
        32'({rdy, valid_n, doe}), 32'h6);

    // every operation code, class chosen by bit 3
    for (int c = 0; c < 16; c++) begin
      if (c[RD_BIT])
        do_read(MODE_W'(c), DATA_W'(16'h5A00 + c * 16'h0123));
      else
        do_write(MODE_W'(c), DATA_W'(16'hA000 ^ (c * 16'h0F11)), (c % 4) * 3, (c % 3) * 5);
      repeat (2) @(negedge clk);
    end

    // every memory address, upper bits of data ignored
    for (int a = 0; a < 16; a++) begin
      do_read(MODE_W'(4'h8 | (a & 7)), DATA_W'((a * 16'h0770) & 16'hFFF0) | DATA_W'(a));
      @(negedge clk);
    end

    // strobe released long before a slow executor finishes
    do_write(4'h1, 16'hBEEF, 12, 0);
    // executor done at once, strobe held long
    do_write(4'h2, 16'h1234, 0, 10);
    do_write(4'h7, 16'hFFFF, 1, 1);
    do_write(4'h0, 16'h0000, 5, 5);

    repeat (5) @(negedge clk);
    chk(rdy && !doe && valid_n, "R9", "drivers off at rest", 32'(doe), 0);
    summary();
  end

endmodule